// File: doc/BRIEF.md
# Shared Management-Interrupt Line Handshake Controller

This block owns one active-low, open-drain style management-interrupt line that a system controller and a processor core share. While the line is idle, the block samples it as a request input. When it sees the line low, it sends the core a one-cycle enter pulse. From then until the handler ends, the block holds the line low, which tells the system controller that the request is being serviced. When the core signals the end of the handler, the block drives the line high for one clock, then stops driving it. Before it accepts another request, it waits until its own sample path has seen the line high. The core can also raise a software entry request. That request enters management mode without driving the line and is reported on a separate flag.

An input selects the sample path. In synchronous mode the line passes through one capture flop. In asynchronous mode it passes through the full synchroniser chain, whose depth is a parameter with a default of two. A global enable gates everything. When the enable is low, the line is never driven and neither request source is accepted.

The controller has five states. `HS_IDLE` waits for a request. `HS_HW_ACTIVE` is a handler entered from the line, with the line held low. `HS_SW_ACTIVE` is a handler entered by software, with the line not driven. `HS_RELEASE` drives the line high for one cycle. `HS_REARM` waits for a high sample before returning to idle. The transitions are:
- `HS_IDLE` to `HS_HW_ACTIVE` when the enable is set and the sample is low.
- `HS_IDLE` to `HS_SW_ACTIVE` when the enable is set, the sample is high and software entry is requested.
- `HS_HW_ACTIVE` to `HS_RELEASE` on resume.
- `HS_SW_ACTIVE` to `HS_IDLE` on resume.
- `HS_RELEASE` to `HS_REARM` always.
- `HS_REARM` to `HS_IDLE` once the sample is high.

Top module: `smi_handshake_ctl`

## Requirements
- R1: In synchronous mode (`async_sel`=0), a line that is low before one rising edge makes `enter` rise after the second rising edge. `enter` is high for exactly one cycle, and `in_mm` rises with it.
- R2: In asynchronous mode (`async_sel`=1), the same request makes `enter` rise after the third rising edge.
- R3: While a handler entered from the line is active, `pin_oe`=1 and `pin_out`=0.
- R4: A `resume` pulse during a line-entered handler gives exactly one cycle of `pin_oe`=1 with `pin_out`=1, then `pin_oe`=0. `in_mm` falls in that same release cycle.
- R5: After a release, no new entry happens until the selected sample path has seen the line high. If the line is held low throughout, `enter` reappears on the 4th rising edge counted from the resume edge in synchronous mode, and on the 5th in asynchronous mode.
- R6: With `smi_en`=0, the line and `sw_req` are ignored, `pin_oe` stays 0 and `in_mm` stays 0.
- R7: `sw_req` in idle gives, after the next edge, `in_mm`=1, `sw_flag`=1 and an `enter` pulse, with `pin_oe` staying 0. A `resume` returns to idle at once with both flags cleared and the line never driven.
- R8: A low line or a `sw_req` during an active handler changes nothing and is not remembered after the handler ends.
- R9: A `resume` outside management mode has no effect. A later request still follows the R1 timing.
- R10: Reset (`rst_n`=0, asynchronous) clears `in_mm`, `sw_flag` and `enter`, and releases the line (`pin_oe`=0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smi_en | input | 1 | Global enable for the line and for software entry |
| async_sel | input | 1 | 1: full synchroniser path, 0: single capture flop |
| pin_in | input | 1 | Resolved level of the shared line |
| pin_out | output | 1 | Level driven onto the line when `pin_oe` is 1 |
| pin_oe | output | 1 | Output enable for the line driver |
| sw_req | input | 1 | Software entry request pulse from the core |
| resume | input | 1 | End-of-handler pulse from the core |
| enter | output | 1 | One-cycle pulse telling the core to enter management mode |
| in_mm | output | 1 | High while a handler is active |
| sw_flag | output | 1 | High while the active handler was entered by software |

## Verification
The assertions assume that `resume` arrives only as a single-cycle pulse and that `async_sel` changes only while the block is idle with the line high. The bench therefore drives `resume` and `sw_req` as one-cycle pulses and switches the sample path only after several idle cycles. The assertions also assume the system controller never fights the one-cycle high release. The bench line model meets this because the block's own drive always overrides the controller's pull-low. The held-low re-arm case shows where that override matters.

// File: rtl/smi_hs_pkg.sv
package smi_hs_pkg;

    typedef enum logic [2:0] {
        HS_IDLE      = 3'd0,
        HS_HW_ACTIVE = 3'd1,
        HS_SW_ACTIVE = 3'd2,
        HS_RELEASE   = 3'd3,
        HS_REARM     = 3'd4
    } hs_state_e;

endpackage

// File: rtl/smi_line_sampler.sv
module smi_line_sampler #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic early_q,
    output logic late_q
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] chain_q;

    // Idle value of the line is high, so reset fills the chain with ones.
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[i] <= 1'b1;
                else        chain_q[i] <= line_in;
            end
        end else begin : g_rest
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[i] <= 1'b1;
                else        chain_q[i] <= chain_q[i-1];
            end
        end
    end

    assign early_q = chain_q[0];
    assign late_q  = chain_q[LAST];

endmodule

// File: rtl/smi_hs_fsm.sv
module smi_hs_fsm
    import smi_hs_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      smi_en,
    input  logic      req_low,
    input  logic      sw_req,
    input  logic      resume,
    output hs_state_e st_q,
    output logic      enter,
    output logic      in_mm,
    output logic      sw_flag,
    output logic      drive_en,
    output logic      drive_lvl
);
    hs_state_e st_d;
    logic      enter_q;

    // Next-state selection
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            HS_IDLE: begin
                if (smi_en && req_low)     st_d = HS_HW_ACTIVE;
                else if (smi_en && sw_req) st_d = HS_SW_ACTIVE;
            end
            HS_HW_ACTIVE: if (resume)   st_d = HS_RELEASE;
            HS_SW_ACTIVE: if (resume)   st_d = HS_IDLE;
            HS_RELEASE:                 st_d = HS_REARM;
            HS_REARM:     if (!req_low) st_d = HS_IDLE;
            default:                    st_d = HS_IDLE;
        endcase
    end

    // State register and entry pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= HS_IDLE;
            enter_q <= 1'b0;
        end else begin
            st_q    <= st_d;
            enter_q <= (st_q == HS_IDLE) &&
                       ((st_d == HS_HW_ACTIVE) || (st_d == HS_SW_ACTIVE));
        end
    end

    // Moore outputs
    always_comb begin
        in_mm     = 1'b0;
        sw_flag   = 1'b0;
        drive_en  = 1'b0;
        drive_lvl = 1'b0;
        unique case (st_q)
            HS_IDLE: ;
            HS_HW_ACTIVE: begin
                in_mm    = 1'b1;
                drive_en = 1'b1;
            end
            HS_SW_ACTIVE: begin
                in_mm   = 1'b1;
                sw_flag = 1'b1;
            end
            HS_RELEASE: begin
                drive_en  = 1'b1;
                drive_lvl = 1'b1;
            end
            HS_REARM: ;
            default: ;
        endcase
    end

    assign enter = enter_q;

    assert_enter_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
        enter |=> !enter);

    assert_hw_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == HS_HW_ACTIVE && resume) |=> (st_q == HS_RELEASE && !in_mm));

    assert_rearm_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == HS_REARM && req_low) |=> (!in_mm && !enter));

    assert_release_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == HS_RELEASE) |=> (!in_mm && !enter));

    assert_disabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == HS_IDLE && !smi_en) |=> !in_mm);

    assert_no_queue_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_mm && !resume) |=> (in_mm && $stable(sw_flag)));

    assert_idle_resume_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == HS_IDLE && !req_low && !sw_req) |=> (st_q == HS_IDLE));

endmodule

// File: rtl/smi_pad_ctl.sv
module smi_pad_ctl (
    input  logic smi_en,
    input  logic drive_en,
    input  logic drive_lvl,
    output logic pin_oe,
    output logic pin_out
);
    // The enable bit has the last word on whether the pad is ever driven.
    always_comb begin
        pin_oe  = smi_en & drive_en;
        pin_out = drive_en & drive_lvl;
    end

endmodule

// File: rtl/smi_handshake_ctl.sv
module smi_handshake_ctl
    import smi_hs_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic smi_en,
    input  logic async_sel,
    input  logic pin_in,
    output logic pin_out,
    output logic pin_oe,
    input  logic sw_req,
    input  logic resume,
    output logic enter,
    output logic in_mm,
    output logic sw_flag
);
    logic      early_q;
    logic      late_q;
    logic      req_low;
    logic      drive_en;
    logic      drive_lvl;
    hs_state_e st_q;

    smi_line_sampler #(.STAGES(SYNC_STAGES)) u_sampler (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_in (pin_in),
        .early_q (early_q),
        .late_q  (late_q)
    );

    assign req_low = async_sel ? !late_q : !early_q;

    smi_hs_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .smi_en    (smi_en),
        .req_low   (req_low),
        .sw_req    (sw_req),
        .resume    (resume),
        .st_q      (st_q),
        .enter     (enter),
        .in_mm     (in_mm),
        .sw_flag   (sw_flag),
        .drive_en  (drive_en),
        .drive_lvl (drive_lvl)
    );

    smi_pad_ctl u_pad (
        .smi_en    (smi_en),
        .drive_en  (drive_en),
        .drive_lvl (drive_lvl),
        .pin_oe    (pin_oe),
        .pin_out   (pin_out)
    );

    assert_active_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_mm && !sw_flag && smi_en) |-> (pin_oe && !pin_out));

    assert_rel_one_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe && pin_out) |=> !pin_oe);

    assert_sw_undriven_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sw_flag |-> !pin_oe);

endmodule

// File: tb/tb_smi_handshake_ctl.sv
module tb_smi_handshake_ctl;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic smi_en = 1'b0;
    logic async_sel = 1'b0;
    logic sw_req = 1'b0;
    logic resume = 1'b0;
    logic chip_low = 1'b0;
    logic pin_line;
    logic pin_out, pin_oe, enter, in_mm, sw_flag;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;   // 8 ns period

    // Open-drain style line: block drive wins, else controller pull-low, else pull-up.
    assign pin_line = pin_oe ? pin_out : ~chip_low;

    smi_handshake_ctl dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .smi_en    (smi_en),
        .async_sel (async_sel),
        .pin_in    (pin_line),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe),
        .sw_req    (sw_req),
        .resume    (resume),
        .enter     (enter),
        .in_mm     (in_mm),
        .sw_flag   (sw_flag)
    );

    typedef struct packed {
        logic       asy;
        logic       en;
        logic [2:0] low_len;
        logic       hit;
        logic [2:0] lat;
    } vec_t;

    localparam vec_t VEC [6] = '{
        '{1'b0, 1'b1, 3'd1, 1'b1, 3'd2},
        '{1'b0, 1'b1, 3'd3, 1'b1, 3'd2},
        '{1'b1, 1'b1, 3'd2, 1'b1, 3'd3},
        '{1'b1, 1'b1, 3'd4, 1'b1, 3'd3},
        '{1'b0, 1'b0, 3'd3, 1'b0, 3'd0},
        '{1'b1, 1'b0, 3'd2, 1'b0, 3'd0}
    };

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        int got;
        int lat;
        int pulses;
        int oe_seen;

        // R10: reset state
        tick();
        tick();
        rst_n = 1'b1;
        tick();
        chk("R10 reset pin_oe", pin_oe, 0);
        chk("R10 reset in_mm", in_mm, 0);
        chk("R10 reset sw_flag", sw_flag, 0);
        chk("R10 reset enter", enter, 0);

        // Table walk: R1, R2, R3, R4, R6
        for (int v = 0; v < 6; v++) begin
            async_sel = VEC[v].asy;
            smi_en = VEC[v].en;
            repeat (4) tick();
            chip_low = 1'b1;
            got = 0;
            lat = 0;
            pulses = 0;
            oe_seen = 0;
            for (int c = 1; c <= 6; c++) begin
                tick();
                if (c == int'(VEC[v].low_len)) chip_low = 1'b0;
                if (enter) begin
                    pulses++;
                    if (got == 0) begin
                        got = 1;
                        lat = c;
                    end
                end
                if (pin_oe) oe_seen = 1;
            end
            if (VEC[v].hit) begin
                chk(VEC[v].asy ? "R2 entry latency" : "R1 entry latency", lat, int'(VEC[v].lat));
                chk("R1 single enter pulse", pulses, 1);
                chk("R3 in_mm during handler", in_mm, 1);
                chk("R3 line driven", pin_oe, 1);
                chk("R3 line low", pin_out, 0);
                resume = 1'b1;
                tick();
                resume = 1'b0;
                chk("R4 release drive", pin_oe, 1);
                chk("R4 release level", pin_out, 1);
                chk("R4 in_mm cleared", in_mm, 0);
                tick();
                chk("R4 line floated", pin_oe, 0);
                repeat (4) tick();
            end else begin
                chk("R6 no entry when disabled", got, 0);
                chk("R6 never driven", oe_seen, 0);
                chk("R6 in_mm stays low", in_mm, 0);
            end
        end

        // R7 / R8: software entry
        async_sel = 1'b0;
        smi_en = 1'b1;
        repeat (3) tick();
        sw_req = 1'b1;
        tick();
        sw_req = 1'b0;
        chk("R7 sw in_mm", in_mm, 1);
        chk("R7 sw flag", sw_flag, 1);
        chk("R7 sw enter", enter, 1);
        chk("R7 sw undriven", pin_oe, 0);
        chip_low = 1'b1;
        tick();
        tick();
        chk("R8 sw flag kept", sw_flag, 1);
        chk("R8 line still undriven", pin_oe, 0);
        chk("R8 no extra enter", enter, 0);
        chip_low = 1'b0;
        tick();
        tick();
        resume = 1'b1;
        tick();
        resume = 1'b0;
        chk("R7 sw exit in_mm", in_mm, 0);
        chk("R7 sw exit flag", sw_flag, 0);
        chk("R7 sw exit undriven", pin_oe, 0);
        got = 0;
        repeat (5) begin
            tick();
            if (enter || in_mm) got = 1;
        end
        chk("R8 no queued entry", got, 0);

        // R6: software entry ignored while disabled
        smi_en = 1'b0;
        sw_req = 1'b1;
        tick();
        sw_req = 1'b0;
        chk("R6 sw ignored in_mm", in_mm, 0);
        chk("R6 sw ignored enter", enter, 0);
        smi_en = 1'b1;
        tick();

        // R9: resume outside a handler
        resume = 1'b1;
        tick();
        resume = 1'b0;
        chk("R9 idle resume in_mm", in_mm, 0);
        chk("R9 idle resume pin_oe", pin_oe, 0);
        tick();
        chip_low = 1'b1;
        tick();
        chk("R9 no early enter", enter, 0);
        tick();
        chk("R9 normal latency after idle resume", enter, 1);
        chip_low = 1'b0;
        sw_req = 1'b1;
        tick();
        sw_req = 1'b0;
        chk("R8 sw during hw handler flag", sw_flag, 0);
        chk("R8 sw during hw handler in_mm", in_mm, 1);
        resume = 1'b1;
        tick();
        resume = 1'b0;
        repeat (4) tick();

        // R5: line held low across the release
        for (int m = 0; m < 2; m++) begin
            async_sel = m[0];
            repeat (4) tick();
            chip_low = 1'b1;
            repeat (m == 1 ? 3 : 2) tick();
            chk("R5 setup entry", enter, 1);
            tick();
            resume = 1'b1;
            tick();
            resume = 1'b0;
            chk("R4 release high under pull-low", pin_out & pin_oe, 1);
            chk("R5 no enter at resume edge", enter, 0);
            got = 0;
            for (int c = 2; c <= 7; c++) begin
                tick();
                if (enter && got == 0) got = c;
            end
            chk(m == 1 ? "R5 async re-entry edge" : "R5 sync re-entry edge", got, m == 1 ? 5 : 4);
            chip_low = 1'b0;
            resume = 1'b1;
            tick();
            resume = 1'b0;
            repeat (5) tick();
        end

        // R10: reset in the middle of a handler
        async_sel = 1'b0;
        chip_low = 1'b1;
        tick();
        tick();
        chk("R10 handler active before reset", in_mm, 1);
        chip_low = 1'b0;
        rst_n = 1'b0;
        #1;
        chk("R10 mid reset pin_oe", pin_oe, 0);
        chk("R10 mid reset in_mm", in_mm, 0);
        chk("R10 mid reset sw_flag", sw_flag, 0);
        chk("R10 mid reset enter", enter, 0);
        tick();
        rst_n = 1'b1;
        tick();
        chk("R10 idle after reset", in_mm, 0);

        summary();
        $finish;
    end

endmodule